// File: doc/BRIEF.md
# On-Off Keyed Carrier Receive Demodulator

This block turns a sampled on-off keyed differential carrier back into data bits, one per channel. Each channel watches a pair of digitized carrier lines, positive and negative. Both lines are brought into the reference clock domain first. The block then looks for rising edges that alternate between the two lines, which is the signature of a carrier that is being driven. When a rising edge on one line follows a rising edge on the other within a programmable window, counted in reference-clock cycles, the carrier is declared present. It is declared absent once a whole window passes with no rising edge.

The carrier-present flag of each channel then goes through a polarity stage that is set per channel. It can be inverted so that a transmitter running with inverted modulation still gives a non-inverting link end to end. A single receive enable, shared by all channels, forces every output to 0 while it is low. The outputs are registered and reset to 0. Typically the window is set to about one and a half carrier periods.

Top module: `okrx_demod`

## Requirements
- R1: While `rx_en` is low, every bit of `dout` is 0 whatever the carrier lines and `pol_inv` do.
- R2: With `rx_en` high and `pol_inv[c]` = 0, `dout[c]` is 1 while a carrier toggles on channel c and 0 while its lines stay idle low.
- R3: With `rx_en` high and `pol_inv[c]` = 1, `dout[c]` is 0 while a carrier is present and 1 while the lines are idle.
- R4: Polarity is set per channel. With a carrier on both channels and `pol_inv` = 2'b01, `dout` reads 2'b10.
- R5: Presence needs a rising edge on one line followed by a rising edge on the other line no more than W cycles later, where W is `win_cycles` and a value of 0 acts as 1. A gap of W+1 cycles, or rising edges on only one line, never sets the output.
- R6: Once the last rising edge is more than W cycles old, the carrier is declared absent and the output goes back to its no-carrier value.
- R7: A sample in which both synchronized lines are high is ignored. It neither counts as an edge nor changes the stored line levels.
- R8: After a synchronous active-high reset, `dout` is 0.
- R9: A rising edge on a line that completes a pair shows on `dout` exactly 4 reference-clock cycles after it is applied: 2 synchronizer stages, the presence register and the output register. At a 250 MHz reference this is 16 ns, well under 100 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_p | input | NCH | Sampled positive carrier line, one per channel |
| rx_n | input | NCH | Sampled negative carrier line, one per channel |
| rx_en | input | 1 | Shared receive enable; low forces all outputs to 0 |
| pol_inv | input | NCH | Per-channel polarity select; 1 inverts the recovered bit |
| win_cycles | input | WIN_W | Presence window in reference-clock cycles |
| dout | output | NCH | Recovered data bit per channel |

## Verification
The hardest cases to reach are the edge of the pairing window and the noise rule. For the window, the bench places one isolated rising edge on each line, exactly W and then W+1 cycles apart, and lets the detector expire fully between the two attempts. For the noise rule, it holds the positive line high and pulses the negative line. A detector that failed to discard the both-high sample would see a negative rising edge that pairs with the earlier positive one. The bench also makes exact-cycle latency checks on that same isolated pair.

// File: rtl/okrx_pkg.sv
package okrx_pkg;
  // Which line produced the most recent rising edge
  typedef enum logic {
    PH_POS = 1'b0,
    PH_NEG = 1'b1
  } phase_t;
endpackage

// File: rtl/okrx_sync.sv
module okrx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/okrx_carrier_det.sv
module okrx_carrier_det
  import okrx_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_p,
  input  logic             s_n,
  input  logic [WIN_W-1:0] win_cycles,
  output logic             present
);
  logic             lvl_p, lvl_n;
  logic             armed;
  phase_t           last_ph;
  logic [WIN_W-1:0] cnt;
  logic [WIN_W-1:0] win_m1;
  logic             valid, rise_p, rise_n, rise_any;

  always_comb begin
    valid    = !(s_p && s_n);
    rise_p   = valid && s_p && !lvl_p;
    rise_n   = valid && s_n && !lvl_n;
    rise_any = rise_p || rise_n;
    win_m1   = (win_cycles == '0) ? '0 : win_cycles - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_p   <= 1'b0;
      lvl_n   <= 1'b0;
      armed   <= 1'b0;
      last_ph <= PH_POS;
      cnt     <= '0;
      present <= 1'b0;
    end else begin
      if (valid) begin
        lvl_p <= s_p;
        lvl_n <= s_n;
      end
      if (rise_any) begin
        cnt     <= '0;
        armed   <= 1'b1;
        last_ph <= rise_n ? PH_NEG : PH_POS;
        if (armed && (last_ph != (rise_n ? PH_NEG : PH_POS)))
          present <= 1'b1;
      end else if (armed) begin
        if (cnt >= win_m1) begin
          armed   <= 1'b0;
          present <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5
  pair_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> $past(rise_any));

  // R6
  expire_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !rise_any && (cnt >= win_m1)) |=> !present);

  // R7
  both_high_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (s_p && s_n) |=> ($stable(lvl_p) && $stable(lvl_n)));
endmodule

// File: rtl/okrx_outstage.sv
module okrx_outstage #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] present,
  input  logic           en,
  input  logic [NCH-1:0] pol,
  output logic [NCH-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst || !en) dout <= '0;
    else            dout <= present ^ pol;
  end

  // R1
  en_low_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (dout == '0));
endmodule

// File: rtl/okrx_demod.sv
module okrx_demod #(
  parameter int NCH   = 2,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   rx_p,
  input  logic [NCH-1:0]   rx_n,
  input  logic             rx_en,
  input  logic [NCH-1:0]   pol_inv,
  input  logic [WIN_W-1:0] win_cycles,
  output logic [NCH-1:0]   dout
);
  localparam int LINES = 2 * NCH;

  logic [LINES-1:0] raw, synced;
  logic [NCH-1:0]   present;

  assign raw = {rx_n, rx_p};

  okrx_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    okrx_carrier_det #(.WIN_W(WIN_W)) u_det (
      .clk        (clk),
      .rst        (rst),
      .s_p        (synced[c]),
      .s_n        (synced[NCH + c]),
      .win_cycles (win_cycles),
      .present    (present[c])
    );
  end

  okrx_outstage #(.NCH(NCH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .present (present),
    .en      (rx_en),
    .pol     (pol_inv),
    .dout    (dout)
  );
endmodule

// File: tb/okrx_demod_tb.sv
module okrx_demod_tb;
  localparam int NCH   = 2;
  localparam int WIN_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic [NCH-1:0]   rx_p, rx_n, pol_inv;
  logic             rx_en;
  logic [WIN_W-1:0] win_cycles;
  logic [NCH-1:0]   dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  okrx_demod #(.NCH(NCH), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst(rst), .rx_p(rx_p), .rx_n(rx_n), .rx_en(rx_en),
    .pol_inv(pol_inv), .win_cycles(win_cycles), .dout(dout)
  );

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    rx_p = '0; rx_n = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic carrier(input logic [NCH-1:0] mask, input int period, input int n);
    for (int i = 0; i < n; i++) begin
      logic ph;
      ph   = (i % period) < (period / 2);
      rx_p = mask & {NCH{ph}};
      rx_n = mask & {NCH{~ph}};
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; rx_en = 1'b1; pol_inv = '1; win_cycles = 8'd12;
    rx_p = '1; rx_n = '0;
    repeat (4) @(negedge clk);
    chk("R8 reset", dout, '0);
    rst = 1'b0; rx_en = 1'b0; pol_inv = '0;
    idle(30);
  endtask

  task automatic t_basic;
    rx_en = 1'b1; pol_inv = '0;
    idle(4);
    chk("R2 idle", dout, 2'b00);
    carrier(2'b01, 8, 40);
    chk("R2 carrier ch0", dout, 2'b01);
    idle(24);
    chk("R6 expired", dout, 2'b00);
  endtask

  task automatic t_polarity;
    rx_en = 1'b1; pol_inv = 2'b11;
    idle(4);
    chk("R3 idle inverted", dout, 2'b11);
    carrier(2'b11, 8, 40);
    chk("R3 carrier inverted", dout, 2'b00);
    pol_inv = 2'b01;
    carrier(2'b11, 8, 8);
    chk("R4 per-channel polarity", dout, 2'b10);
    idle(24);
    chk("R4 idle per-channel", dout, 2'b01);
  endtask

  task automatic t_enable;
    rx_en = 1'b0; pol_inv = 2'b01;
    carrier(2'b11, 8, 40);
    chk("R1 enable low carrier", dout, 2'b00);
    idle(24);
    chk("R1 enable low idle", dout, 2'b00);
    rx_en = 1'b1;
    idle(24);
  endtask

  task automatic t_one_line;
    bit bad = 1'b0;
    rx_en = 1'b1; pol_inv = '0;
    for (int i = 0; i < 40; i++) begin
      rx_p = {NCH{(i % 8) < 4}}; rx_n = '0;
      @(negedge clk);
      if (dout !== '0) bad = 1'b1;
    end
    chk("R5 single line", bad ? 2'b11 : 2'b00, 2'b00);
    idle(24);
  endtask

  task automatic t_noise;
    bit bad = 1'b0;
    rx_en = 1'b1; pol_inv = '0;
    rx_p = '1; rx_n = '0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      rx_n = {NCH{(i % 4) == 0}};
      @(negedge clk);
      if (dout !== '0) bad = 1'b1;
    end
    chk("R7 both-high ignored", bad ? 2'b11 : 2'b00, 2'b00);
    idle(24);
  endtask

  task automatic t_pair(input int gap, input bit expect_set);
    bit seen = 1'b0;
    rx_en = 1'b1; pol_inv = '0; win_cycles = 8'd12;
    rx_p = 2'b01; rx_n = '0;
    repeat (2) @(negedge clk);
    rx_p = '0;
    repeat (gap - 2) @(negedge clk);
    rx_n = 2'b01;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) rx_n = '0;
      if (expect_set && k < 4) chk("R9 latency early", dout, 2'b00);
      if (expect_set && k == 4) chk("R9 latency 4 cycles", dout, 2'b01);
    end
    if (!expect_set) begin
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (dout !== '0) seen = 1'b1;
      end
      chk("R5 gap W+1 rejected", seen ? 2'b01 : 2'b00, 2'b00);
    end else begin
      chk("R5 gap W accepted", dout, 2'b01);
    end
    idle(30);
    chk("R6 pair expired", dout, 2'b00);
  endtask

  task automatic t_window;
    rx_en = 1'b1; pol_inv = '0; win_cycles = 8'd6;
    carrier(2'b11, 16, 48);
    chk("R5 slow carrier small window", dout, 2'b00);
    carrier(2'b11, 8, 40);
    chk("R5 fast carrier small window", dout, 2'b11);
    idle(24);
    chk("R6 small window expired", dout, 2'b00);
    win_cycles = 8'd12;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_enable();
    t_one_line();
    t_noise();
    t_pair(12, 1'b1);
    t_pair(13, 1'b0);
    t_window();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule